// File: doc/BRIEF.md
# Byte-Wide General-Purpose I/O Port

This block is one eight-pin general-purpose I/O port with a small register bus. The bus has an address, a write strobe, write data and read data. The port holds three registers: an output latch, a direction register and a control register. A fourth offset is read-only and returns the pin levels, sampled through a synchronizer. For every pin the port drives three signals into a separate pad model: the level to drive, an output enable and a pull-up enable. The pad model returns the level it sees on the pin.

The meaning of each control bit depends on the direction of its pin. In input mode the bit selects a floating input or a pulled-up input. In output mode it selects push-pull or pseudo-open-drain driving. A write to the output latch is always kept, even while the pin is an input, and the stored value drives the pin once the pin becomes an output. The reset value of the control register is a parameter, so that one port instance can come out of reset with a different default.

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch and the direction register read 0x00, the control register reads the value of parameter CTRL_RST (0x00 by default), and every pad output enable is low.
- R2: A read of offset 0x00 returns the value last written to the output latch, whatever the pin levels are.
- R3: Direction bit i at offset 0x02 sets pin i to input when it is 0 and to output when it is 1. A pin in input mode never has its output enable asserted.
- R4: A write to the output latch while a pin is in input mode is stored but does not enable that pin's driver. When the pin later switches to output, it drives the stored value.
- R5: A pin in output mode whose control bit (offset 0x03) is 1 is push-pull: its output enable is high and its pad output equals its latch bit.
- R6: A pin in output mode whose control bit is 0 is pseudo-open-drain: for a latch bit of 0 it enables the driver with a low level, and for a latch bit of 1 its output enable is low.
- R7: The pull-up enable of a pin is high only when the pin is in input mode and its control bit is 1. It is low for every output mode.
- R8: A read of offset 0x01 returns the pin levels as they were two clock edges earlier, through a two-stage synchronizer, in both input and output mode.
- R9: Writes to offset 0x01 and to unmapped offsets (0x04 to 0x07) change no register and no pad output. Reads of unmapped offsets return 0x00.
- R10: A write takes effect at the rising clock edge on which the write strobe is sampled high. Reads are combinational from the current register contents, so before that edge a read returns the old value.
- R11: An instance built with CTRL_RST = 0x02 resets its control register to 0x02, so pin 1 comes out of reset as a pulled-up input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (3) | Register offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | PORT_W (8) | Write data |
| bus_rdata | output | PORT_W (8) | Combinational read data for bus_addr |
| pin_in | input | PORT_W (8) | Pin levels returned by the pad model |
| pad_out | output | PORT_W (8) | Level to drive on each pin |
| pad_oe | output | PORT_W (8) | Driver enable for each pin |
| pad_pu | output | PORT_W (8) | Pull-up enable for each pin |

## Verification
The bench goes after the cases where direction changes the meaning of a bit. A latch written in input mode must not leak onto the pad, or the port would drive pins that are meant to float. Pseudo-open-drain pins with a latched 1 must release the pin, or the port would contend with other drivers on a shared line. A design that left pull-ups on in output mode, or that read the pin register without the synchronizer delay, shows a wrong pad_pu or a read value one cycle early. Writes to the pin register and to unmapped offsets are checked against every readable register and the pad outputs. A second instance with a different control reset value confirms that the parameter reaches the register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Offsets are decoded by software, so they are fixed.
  localparam int unsigned OFS_LATCH = 0;
  localparam int unsigned OFS_PINS  = 1;
  localparam int unsigned OFS_DIR   = 2;
  localparam int unsigned OFS_CTRL  = 3;

  typedef struct packed {
    logic out;
    logic oe;
    logic pu;
  } pad_drive_t;

  // Per-pin drive decode: direction and control bit select the mode.
  function automatic pad_drive_t decode_pin(input logic dir, input logic ctl, input logic lat);
    pad_drive_t d;
    d = '0;
    if (!dir) begin
      d.pu = ctl;                 // input: pulled-up or floating
    end else if (ctl) begin
      d.out = lat;                // push-pull
      d.oe  = 1'b1;
    end else begin
      d.out = 1'b0;               // pseudo-open-drain: low only
      d.oe  = ~lat;
    end
    return d;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

  // R8: the first stage captures the pin level of the previous cycle
  a_r8_first_stage: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stage_q[0] == $past(din));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int               PORT_W   = 8,
  parameter int               ADDR_W   = 3,
  parameter logic [PORT_W-1:0] CTRL_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic [PORT_W-1:0] pins_sync,
  output logic [PORT_W-1:0] bus_rdata,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] ctrl_q
);

  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(OFS_LATCH);
  localparam logic [ADDR_W-1:0] A_PINS  = ADDR_W'(OFS_PINS);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);

  logic wr_latch, wr_dir, wr_ctrl;

  assign wr_latch = bus_we && (bus_addr == A_LATCH);
  assign wr_dir   = bus_we && (bus_addr == A_DIR);
  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      ctrl_q  <= CTRL_RST;
    end else begin
      if (wr_latch) latch_q <= bus_wdata;
      if (wr_dir)   dir_q   <= bus_wdata;
      if (wr_ctrl)  ctrl_q  <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_LATCH: bus_rdata = latch_q;
      A_PINS:  bus_rdata = pins_sync;
      A_DIR:   bus_rdata = dir_q;
      A_CTRL:  bus_rdata = ctrl_q;
      default: bus_rdata = '0;
    endcase
  end

  // R1: state after a reset cycle
  a_r1_reset_values: assert property (@(posedge clk)
    $past(rst) |-> (latch_q == '0 && dir_q == '0 && ctrl_q == CTRL_RST));

  // R10: a latch write lands on the strobe edge
  a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_LATCH) |=> latch_q == $past(bus_wdata));

  // R9: writes off the writable offsets leave every register alone
  a_r9_ignored_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr != A_LATCH && bus_addr != A_DIR && bus_addr != A_CTRL)
      |=> ($stable(latch_q) && $stable(dir_q) && $stable(ctrl_q)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic [PORT_W-1:0] latch_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] ctrl_q,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_pu
);

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    pad_drive_t drv;
    assign drv        = decode_pin(dir_q[i], ctrl_q[i], latch_q[i]);
    assign pad_out[i] = drv.out;
    assign pad_oe[i]  = drv.oe;
    assign pad_pu[i]  = drv.pu;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int               PORT_W      = 8,
  parameter int               ADDR_W      = 3,
  parameter int               SYNC_STAGES = 2,
  parameter logic [PORT_W-1:0] CTRL_RST    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_pu
);

  logic [PORT_W-1:0] pins_sync;
  logic [PORT_W-1:0] latch_q, dir_q, ctrl_q;

  gpio_pin_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (pins_sync)
  );

  gpio_port_regs #(.PORT_W(PORT_W), .ADDR_W(ADDR_W), .CTRL_RST(CTRL_RST)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pins_sync (pins_sync),
    .bus_rdata (bus_rdata),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .ctrl_q    (ctrl_q)
  );

  gpio_pad_ctrl #(.PORT_W(PORT_W)) u_pad (
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .ctrl_q  (ctrl_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_pu  (pad_pu)
  );

  // R3: no driver on an input pin
  a_r3_no_drive_on_input: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~dir_q) == '0);

  // R6: pseudo-open-drain pins never drive high
  a_r6_od_never_high: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_out & dir_q & ~ctrl_q) == '0);

  // R7: pull-ups are off on every output pin
  a_r7_no_pullup_on_output: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & dir_q) == '0);

endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/100ps
module gpio_port_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] pin_in = '0;
  logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu;
  logic [7:0] alt_rdata, alt_out, alt_oe, alt_pu;

  always #2.5 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  gpio_port #(.CTRL_RST(8'h02)) u_dut_alt (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(alt_rdata), .pin_in(pin_in),
    .pad_out(alt_out), .pad_oe(alt_oe), .pad_pu(alt_pu)
  );

  // Scoreboard: 0 rdata, 1 pad_out, 2 pad_oe, 3 pad_pu, 4 alt rdata, 5 alt pad_pu
  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  event  ev_chk;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  initial begin
    forever begin
      @(ev_chk);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = q.pop_front();
        case (it.sel)
          0: got = bus_rdata;
          1: got = pad_out;
          2: got = pad_oe;
          3: got = pad_pu;
          4: got = alt_rdata;
          default: got = alt_pu;
        endcase
        checks++;
        if (got !== it.exp) begin
          failures++;
          $display("FAIL %s: got %02h expected %02h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic expect_sig(input int sel, input logic [7:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    ->ev_chk;
    #0.1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #0.1;
    expect_sig(0, exp, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    #0.1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #0.1;
    // R1: reset state
    rd(3'd0, 8'h00, "R1 latch reset");
    rd(3'd2, 8'h00, "R1 dir reset");
    rd(3'd3, 8'h00, "R1 ctrl reset");
    expect_sig(2, 8'h00, "R1 oe reset");
    expect_sig(3, 8'h00, "R7 no pull-up at reset");
    // R11: alternate reset value
    bus_addr = 3'd3; #0.1;
    expect_sig(4, 8'h02, "R11 alt ctrl reset");
    expect_sig(5, 8'h02, "R11 alt pin1 pulled up");

    // R10: old value before the edge, new after
    @(negedge clk);
    bus_addr = 3'd0; bus_we = 1'b1; bus_wdata = 8'hA5;
    #0.1;
    expect_sig(0, 8'h00, "R10 read before edge");
    @(negedge clk);
    bus_we = 1'b0;
    rd(3'd0, 8'hA5, "R2 latch readback");
    // R4: latched in input mode, no drive
    expect_sig(2, 8'h00, "R4 no drive in input mode");

    // R8: pin synchronizer delay
    @(negedge clk);
    pin_in = 8'h3C;
    rd(3'd1, 8'h00, "R8 pins before edges");
    @(negedge clk);
    rd(3'd1, 8'h00, "R8 pins after one edge");
    @(negedge clk);
    rd(3'd1, 8'h3C, "R8 pins after two edges");
    rd(3'd0, 8'hA5, "R2 latch not pin level");

    // R5: push-pull, R4 stored value appears
    wr(3'd3, 8'hFF);
    wr(3'd2, 8'hFF);
    expect_sig(2, 8'hFF, "R5 push-pull oe");
    expect_sig(1, 8'hA5, "R4 R5 stored latch driven");
    expect_sig(3, 8'h00, "R7 no pull-up push-pull");

    // R6: pseudo-open-drain
    wr(3'd3, 8'h00);
    expect_sig(2, 8'h5A, "R6 od oe for latch zeros");
    expect_sig(1, 8'h00, "R6 od drives low only");

    // R3 and R7: mixed directions
    wr(3'd2, 8'h0F);
    wr(3'd3, 8'hF0);
    expect_sig(3, 8'hF0, "R7 pull-up on input pins");
    expect_sig(2, 8'h0A, "R3 only output pins enabled");

    // R8 in output mode
    @(negedge clk);
    pin_in = 8'hC3;
    @(negedge clk);
    @(negedge clk);
    rd(3'd1, 8'hC3, "R8 pins in output mode");

    // R9: ignored writes
    wr(3'd1, 8'h00);
    wr(3'd5, 8'hFF);
    wr(3'd7, 8'h55);
    rd(3'd0, 8'hA5, "R9 latch unchanged");
    rd(3'd2, 8'h0F, "R9 dir unchanged");
    rd(3'd3, 8'hF0, "R9 ctrl unchanged");
    rd(3'd1, 8'hC3, "R9 pin reg unchanged");
    expect_sig(2, 8'h0A, "R9 oe unchanged");
    expect_sig(3, 8'hF0, "R9 pull-up unchanged");
    rd(3'd4, 8'h00, "R9 unmapped 4 reads zero");
    rd(3'd6, 8'h00, "R9 unmapped 6 reads zero");
    rd(3'd7, 8'h00, "R9 unmapped 7 reads zero");

    // R4: latch write while pins 7:4 are inputs, then switch
    wr(3'd0, 8'hF0);
    expect_sig(2, 8'h0F, "R4 inputs stay released");
    wr(3'd3, 8'hFF);
    wr(3'd2, 8'hFF);
    expect_sig(1, 8'hF0, "R4 latched value driven");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule